// File: doc/BRIEF.md
# Register Rename Map with Free List

This block is the rename stage of an out-of-order integer core with 32 architectural and 64 physical registers. Each cycle it accepts at most one instruction. It translates the two source register numbers into physical tags through a map table. When the instruction writes a register, it takes a fresh physical tag from the head of a free list, points the destination's map entry at that tag, and reports the tag that was mapped there before. That old tag travels with the instruction and comes back on the retire port when the instruction commits, and it then goes onto the tail of the free list.

A single checkpoint slot supports branch recovery. Taking a checkpoint copies the whole map table and the free-list head pointer. A restore copies both back, which drops every speculative mapping and hands the tags allocated since the checkpoint back to the free list. Releases that arrived in between are kept, because the tail pointer is never rewound. A small state machine holds the slot. In CK_IDLE a take request snapshots the state and moves to CK_HELD. In CK_HELD a restore request rolls the state back and returns to CK_IDLE, and a discard request (branch resolved correctly) returns to CK_IDLE without rolling back. Other requests leave the state unchanged.

Architectural register 0 reads as zero: it always maps to physical 0 and never consumes a tag.

Top module: `rn_rename`

## Requirements
- R1: After reset, architectural register i maps to physical i. The free list holds physical 32 to 63 and hands them out in ascending order, first 32.
- R2: The source tags are the current map entries, looked up combinationally in the same cycle. An instruction whose source equals its destination receives the mapping in force before its own update.
- R3: An accepted instruction with the write flag set and a nonzero destination receives the free-list head as its new tag. The map entry holds that tag from the next cycle on, and each such allocation removes exactly one tag from the free list.
- R4: The old-tag output gives the physical tag mapped to the destination just before the update.
- R5: Architectural 0 always looks up as physical 0. A destination of 0, or a clear write flag, allocates nothing, and both the new-tag and old-tag outputs read 0.
- R6: A retire request pushes its tag onto the tail of the free list, where it is handed out after every tag already there. A retire request carrying tag 0 is ignored.
- R7: While the free list is empty, ready is low and a presented instruction neither allocates nor changes the map.
- R8: In CK_IDLE a take request snapshots the map and the free-list head as they were before any rename in the same cycle, and moves the slot to CK_HELD.
- R9: In CK_HELD a restore request puts back the snapshot map and head pointer and returns to CK_IDLE. Tags released since the snapshot stay free. Ready is low in any cycle in which restore is requested.
- R10: A take request in CK_HELD is ignored and the first snapshot is kept. A restore request in CK_IDLE leaves the map and free list unchanged.
- R11: In CK_HELD a discard request returns to CK_IDLE and keeps the current speculative map, so a later restore has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_src_a | input | 5 | First source architectural register |
| ren_src_b | input | 5 | Second source architectural register |
| ren_dst | input | 5 | Destination architectural register |
| ren_dst_we | input | 1 | Instruction writes its destination |
| ren_ready | output | 1 | Rename can accept this cycle |
| ren_ptag_a | output | 6 | Physical tag of the first source |
| ren_ptag_b | output | 6 | Physical tag of the second source |
| ren_pdst | output | 6 | Newly allocated destination tag, 0 if none |
| ren_pold | output | 6 | Tag previously mapped to the destination, 0 if none |
| ret_valid | input | 1 | A retiring instruction releases a tag |
| ret_ptag | input | 6 | Tag to return to the free list |
| ck_take | input | 1 | Snapshot the rename state at a branch |
| ck_restore | input | 1 | Roll back to the snapshot after a mispredict |
| ck_discard | input | 1 | Drop the snapshot after a correct prediction |

## Verification
The first pattern sweeps every destination in turn with the source set to the same register, while the free list drains from full to empty. Any slip in the lookup-before-update order, or in the order tags are handed out, shows up on each of the 31 steps. The second pattern retires old tags in order and then reallocates. This separates correct tail insertion from a list that reuses its initial contents, and the tag-0 release probe confirms that such a release adds nothing. Checkpoint patterns take a snapshot in the same cycle as a rename, issue a second take while the slot is held, restore with no slot held, and discard before a restore. Each distinguishes a different ordering of snapshot, update and rollback. A long arithmetic stream then mixes renames, retirements and periodic checkpoint/restore pairs, and compares every tag against a reference map and free queue kept in the bench.

// File: rtl/rn_pkg.sv
package rn_pkg;

    // Checkpoint slot occupancy
    typedef enum logic [0:0] {
        CK_IDLE = 1'b0,
        CK_HELD = 1'b1
    } ck_state_e;

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int ARCH = 32,
    parameter int PHYS = 64,
    localparam int AW = $clog2(ARCH),
    localparam int PW = $clog2(PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    input  logic [AW-1:0] rd_c,
    output logic [PW-1:0] tag_a,
    output logic [PW-1:0] tag_b,
    output logic [PW-1:0] tag_c,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [PW-1:0] wr_tag,
    input  logic          snap_en,
    input  logic          rest_en
);

    logic [PW-1:0] cur   [ARCH];
    logic [PW-1:0] saved [ARCH];

    // Entry 0 reads as physical 0 whatever the array holds
    assign tag_a = (rd_a == '0) ? '0 : cur[rd_a];
    assign tag_b = (rd_b == '0) ? '0 : cur[rd_b];
    assign tag_c = (rd_c == '0) ? '0 : cur[rd_c];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH; i++) begin
                cur[i]   <= PW'(i);
                saved[i] <= PW'(i);
            end
        end else begin
            if (snap_en) begin
                for (int i = 0; i < ARCH; i++) saved[i] <= cur[i];
            end
            if (rest_en) begin
                for (int i = 0; i < ARCH; i++) cur[i] <= saved[i];
            end else if (wr_en && (wr_addr != '0)) begin
                cur[wr_addr] <= wr_tag;
            end
        end
    end

endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int ARCH = 32,
    parameter int PHYS = 64,
    localparam int PW    = $clog2(PHYS),
    localparam int DEPTH = PHYS - ARCH,
    localparam int IW    = $clog2(DEPTH),
    localparam int PTRW  = IW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pop,
    input  logic            push,
    input  logic [PW-1:0]   push_tag,
    input  logic            snap_en,
    input  logic            rest_en,
    output logic [PW-1:0]   head_tag,
    output logic            empty,
    output logic [PTRW-1:0] count
);

    logic [PW-1:0]   slots [DEPTH];
    logic [PTRW-1:0] head, tail, head_ck;
    logic            push_ok;

    // Pointers carry a wrap bit so full and empty stay distinct
    assign count    = tail - head;
    assign empty    = (count == '0);
    assign head_tag = slots[head[IW-1:0]];
    assign push_ok  = push && (push_tag != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= PW'(ARCH + i);
        end else if (push_ok) begin
            slots[tail[IW-1:0]] <= push_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head    <= '0;
            tail    <= PTRW'(DEPTH);
            head_ck <= '0;
        end else begin
            if (push_ok) tail <= tail + 1'b1;
            if (rest_en)                 head <= head_ck;
            else if (pop && !empty)      head <= head + 1'b1;
            if (snap_en) head_ck <= head;
        end
    end

endmodule

// File: rtl/rn_ckpt_ctrl.sv
module rn_ckpt_ctrl
    import rn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic restore,
    input  logic discard,
    output logic snap_en,
    output logic rest_en
);

    ck_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CK_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CK_IDLE: if (take) state_nx = CK_HELD;
            CK_HELD: if (restore || discard) state_nx = CK_IDLE;
            default: state_nx = CK_IDLE;
        endcase
    end

    always_comb begin
        snap_en = 1'b0;
        rest_en = 1'b0;
        unique case (state)
            CK_IDLE: snap_en = take;
            CK_HELD: rest_en = restore;
            default: ;
        endcase
    end

endmodule

// File: rtl/rn_rename.sv
module rn_rename #(
    parameter int ARCH = 32,
    parameter int PHYS = 64,
    localparam int AW    = $clog2(ARCH),
    localparam int PW    = $clog2(PHYS),
    localparam int DEPTH = PHYS - ARCH,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_src_a,
    input  logic [AW-1:0] ren_src_b,
    input  logic [AW-1:0] ren_dst,
    input  logic          ren_dst_we,
    output logic          ren_ready,
    output logic [PW-1:0] ren_ptag_a,
    output logic [PW-1:0] ren_ptag_b,
    output logic [PW-1:0] ren_pdst,
    output logic [PW-1:0] ren_pold,
    input  logic          ret_valid,
    input  logic [PW-1:0] ret_ptag,
    input  logic          ck_take,
    input  logic          ck_restore,
    input  logic          ck_discard
);

    logic          fl_empty;
    logic [CW-1:0] fl_count;
    logic [PW-1:0] fl_head;
    logic [PW-1:0] old_tag;
    logic          snap_en, rest_en;
    logic          wants_reg, alloc;

    assign wants_reg = ren_dst_we && (ren_dst != '0);
    assign ren_ready = !fl_empty && !ck_restore;
    assign alloc     = ren_valid && ren_ready && wants_reg;
    assign ren_pdst  = (wants_reg && !fl_empty) ? fl_head : '0;
    assign ren_pold  = wants_reg ? old_tag : '0;

    rn_ckpt_ctrl u_ckpt (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (ck_take),
        .restore (ck_restore),
        .discard (ck_discard),
        .snap_en (snap_en),
        .rest_en (rest_en)
    );

    rn_map_table #(.ARCH(ARCH), .PHYS(PHYS)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_a    (ren_src_a),
        .rd_b    (ren_src_b),
        .rd_c    (ren_dst),
        .tag_a   (ren_ptag_a),
        .tag_b   (ren_ptag_b),
        .tag_c   (old_tag),
        .wr_en   (alloc),
        .wr_addr (ren_dst),
        .wr_tag  (fl_head),
        .snap_en (snap_en),
        .rest_en (rest_en)
    );

    rn_free_list #(.ARCH(ARCH), .PHYS(PHYS)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (ret_valid),
        .push_tag (ret_ptag),
        .snap_en  (snap_en),
        .rest_en  (rest_en),
        .head_tag (fl_head),
        .empty    (fl_empty),
        .count    (fl_count)
    );

endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int ARCH = 32,
    parameter int PHYS = 64,
    localparam int AW    = $clog2(ARCH),
    localparam int PW    = $clog2(PHYS),
    localparam int DEPTH = PHYS - ARCH,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ren_valid,
    input logic [AW-1:0] ren_src_a,
    input logic [AW-1:0] ren_src_b,
    input logic [AW-1:0] ren_dst,
    input logic          ren_dst_we,
    input logic          ren_ready,
    input logic [PW-1:0] ren_ptag_a,
    input logic [PW-1:0] ren_ptag_b,
    input logic [PW-1:0] ren_pdst,
    input logic [PW-1:0] ren_pold,
    input logic          ret_valid,
    input logic [PW-1:0] ret_ptag,
    input logic          ck_restore,
    input logic [CW-1:0] fl_count
);

    logic alloc_w, push_w;
    assign alloc_w = ren_valid && ren_ready && ren_dst_we && (ren_dst != '0);
    assign push_w  = ret_valid && (ret_ptag != '0);

    p_x0_src_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_src_a == '0) |-> (ren_ptag_a == '0));

    p_x0_src_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_src_b == '0) |-> (ren_ptag_b == '0));

    p_x0_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && (ren_dst == '0)) |-> (ren_pdst == '0 && ren_pold == '0));

    p_empty_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_count == '0) |-> !ren_ready);

    p_restore_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ck_restore |-> !ren_ready);

    p_fresh_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_w |-> (ren_pdst != '0 && ren_pdst != ren_pold));

    p_alloc_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_w && !push_w) |=> (fl_count == $past(fl_count) - 1'b1));

    p_release_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_w && !alloc_w && !ck_restore) |=> (fl_count == $past(fl_count) + 1'b1));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_count <= CW'(DEPTH));

endmodule

bind rn_rename rn_rename_chk #(.ARCH(ARCH), .PHYS(PHYS)) u_chk (.*);

// File: tb/tb_rn_rename.sv
`timescale 1ns/1ps
module tb_rn_rename;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0;
    logic [4:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic       ren_dst_we = 1'b0;
    logic       ren_ready;
    logic [5:0] ren_ptag_a, ren_ptag_b, ren_pdst, ren_pold;
    logic       ret_valid = 1'b0;
    logic [5:0] ret_ptag = '0;
    logic       ck_take = 1'b0, ck_restore = 1'b0, ck_discard = 1'b0;

    always #4 clk = ~clk;

    rn_rename dut (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model
    int ref_map [32];
    int fq [32];
    int fh, ft;
    int rob [64];
    int rh, rt;
    int ck_map [32];
    int ck_fh, ck_rt;
    bit ck_held;

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_map(input string req);
        ren_valid = 1'b0;
        for (int r = 0; r < 32; r++) begin
            ren_src_a = 5'(r);
            ren_src_b = 5'(31 - r);
            #0.2;
            chk(int'(ren_ptag_a) == ref_map[r], req, int'(ren_ptag_a), ref_map[r]);
            chk(int'(ren_ptag_b) == ref_map[31 - r], req, int'(ren_ptag_b), ref_map[31 - r]);
        end
        @(negedge clk);
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic do_ren(input int sa, input int sb, input int d, input bit we, input bit rtr);
        bit exp_rdy, alloc;
        int e_pd, e_po, rtag;
        ren_valid  = 1'b1;
        ren_src_a  = 5'(sa);
        ren_src_b  = 5'(sb);
        ren_dst    = 5'(d);
        ren_dst_we = we;
        rtag = 0;
        if (rtr) begin
            rtag = rob[rh % 64];
            ret_valid = 1'b1;
            ret_ptag  = 6'(rtag);
        end
        #1;
        exp_rdy = (ft - fh) != 0;
        alloc = we && (d != 0) && exp_rdy;
        e_pd = alloc ? fq[fh % 32] : 0;
        e_po = alloc ? ref_map[d] : 0;
        chk(ren_ready == exp_rdy, "R7 ready", int'(ren_ready), int'(exp_rdy));
        chk(int'(ren_ptag_a) == ref_map[sa], "R2 src a", int'(ren_ptag_a), ref_map[sa]);
        chk(int'(ren_ptag_b) == ref_map[sb], "R2 src b", int'(ren_ptag_b), ref_map[sb]);
        if (exp_rdy) begin
            chk(int'(ren_pdst) == e_pd, (d == 0 || !we) ? "R5 pdst" : "R3 pdst", int'(ren_pdst), e_pd);
            chk(int'(ren_pold) == e_po, (d == 0 || !we) ? "R5 pold" : "R4 pold", int'(ren_pold), e_po);
        end
        @(negedge clk);
        if (alloc) begin
            ref_map[d] = e_pd;
            fh++;
            rob[rt % 64] = e_po;
            rt++;
        end
        if (rtr) begin
            fq[ft % 32] = rtag;
            ft++;
            rh++;
        end
        ren_valid = 1'b0;
        ret_valid = 1'b0;
    endtask

    task automatic snap_ref();
        if (!ck_held) begin
            for (int i = 0; i < 32; i++) ck_map[i] = ref_map[i];
            ck_fh = fh;
            ck_rt = rt;
            ck_held = 1'b1;
        end
    endtask

    task automatic do_take();
        ck_take = 1'b1;
        @(negedge clk);
        ck_take = 1'b0;
        snap_ref();
    endtask

    task automatic do_restore(input string req);
        ck_restore = 1'b1;
        #1;
        chk(ren_ready == 1'b0, req, int'(ren_ready), 0);
        @(negedge clk);
        ck_restore = 1'b0;
        if (ck_held) begin
            for (int i = 0; i < 32; i++) ref_map[i] = ck_map[i];
            fh = ck_fh;
            rt = ck_rt;
            ck_held = 1'b0;
        end
    endtask

    task automatic do_discard();
        ck_discard = 1'b1;
        @(negedge clk);
        ck_discard = 1'b0;
        ck_held = 1'b0;
    endtask

    function automatic bit can_ret(input int k);
        return (rh < rt) && (!ck_held || rh < ck_rt) && (((k % 3) != 0) || (ft - fh) == 0);
    endfunction

    initial begin
        for (int i = 0; i < 32; i++) begin
            ref_map[i] = i;
            fq[i] = 32 + i;
        end
        fh = 0; ft = 32; rh = 0; rt = 0; ck_held = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset mapping and first tag
        chk(ren_ready == 1'b1, "R1 ready after reset", int'(ren_ready), 1);
        check_map("R1 identity map");
        ren_dst = 5'd1; ren_dst_we = 1'b1;
        #1;
        chk(int'(ren_pdst) == 32, "R1 first free tag", int'(ren_pdst), 32);
        @(negedge clk);

        // R2/R3/R4: every destination, source equal to destination
        for (int d = 1; d < 32; d++) do_ren(d, (d + 1) % 32, d, 1'b1, 1'b0);
        check_map("R3 map after sweep");

        // R5: x0 and no-write instructions allocate nothing
        do_ren(0, 4, 0, 1'b1, 1'b0);
        do_ren(5, 0, 7, 1'b0, 1'b0);
        do_ren(2, 2, 1, 1'b1, 1'b0);
        chk(ref_map[1] == 63, "R5 no tag consumed", ref_map[1], 63);

        // R7: empty free list stalls
        do_ren(1, 2, 3, 1'b1, 1'b0);
        check_map("R7 map unchanged when empty");

        // R6: tag 0 release is ignored
        ret_valid = 1'b1; ret_ptag = '0;
        @(negedge clk);
        ret_valid = 1'b0;
        ren_valid = 1'b1; ren_dst = 5'd3; ren_dst_we = 1'b1;
        #1;
        chk(ren_ready == 1'b0, "R6 zero release ignored", int'(ren_ready), 0);
        @(negedge clk);
        ren_valid = 1'b0;

        // R6: releases come back in order
        for (int i = 0; i < 10; i++) begin
            fq[ft % 32] = rob[rh % 64];
            ret_valid = 1'b1; ret_ptag = 6'(rob[rh % 64]);
            @(negedge clk);
            ft++; rh++;
        end
        ret_valid = 1'b0;
        for (int i = 0; i < 4; i++) do_ren(i + 3, i, i + 3, 1'b1, 1'b0);

        // R8/R9: snapshot in a rename cycle, roll back, keep releases
        ck_take = 1'b1;
        snap_ref();
        do_ren(4, 5, 6, 1'b1, 1'b0);
        ck_take = 1'b0;
        do_ren(6, 6, 6, 1'b1, 1'b1);
        do_ren(9, 6, 10, 1'b1, 1'b1);
        do_ren(10, 1, 11, 1'b1, 1'b0);
        do_restore("R9 ready low on restore");
        check_map("R9 map restored");
        do_ren(6, 7, 12, 1'b1, 1'b0);
        do_ren(1, 2, 13, 1'b1, 1'b0);

        // R10: second take ignored, idle restore ignored
        do_take();
        do_ren(1, 1, 14, 1'b1, 1'b0);
        do_take();
        do_ren(14, 2, 15, 1'b1, 1'b0);
        do_restore("R10 ready low on restore");
        check_map("R10 first snapshot kept");
        do_restore("R10 ready low on idle restore");
        check_map("R10 idle restore no effect");
        do_ren(15, 14, 16, 1'b1, 1'b0);

        // R11: discard keeps speculative state
        do_take();
        do_ren(3, 4, 17, 1'b1, 1'b0);
        do_discard();
        do_ren(17, 4, 18, 1'b1, 1'b0);
        do_restore("R11 ready low on restore");
        check_map("R11 map kept after discard");

        // Mixed stream with periodic checkpoint recovery
        for (int k = 0; k < 3000; k++) begin
            if ((k % 200) == 10 && !ck_held) do_take();
            else if ((k % 200) == 60) do_restore("R9 stream restore");
            else do_ren((k * 7) % 32, (k * 13 + 5) % 32, (k * 11 + 3) % 32,
                        (k % 5) != 0, can_ret(k));
        end
        check_map("R3 final map");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule